// File: doc/BRIEF.md
# Programmable 3x3 Colour Matrix Multiplier

This block multiplies a stream of three-channel pixel samples by a programmable 3x3 matrix. Each output channel is a weighted sum of the three inputs. For row r, the output is k(r,0)*A + k(r,1)*B + k(r,2)*C. The nine weights are 12-bit signed fixed-point values with 3 integer bits and 9 fraction bits. They are written byte by byte through a small register port and can be read back through the same port. It is used to convert between colour spaces in either direction, for example RGB to luminance and colour difference, or the reverse.

Samples enter and leave over valid/ready handshakes. Each input channel is a signed fixed-point word with 10 integer bits and 3 fraction bits. The arithmetic runs through three register stages, and each product is trimmed to 6 fraction bits before the row sum. A per-sample width select decides how many integer bits reach the output: 10 when producing RGB, 9 when producing colour difference.

Back-pressure is global. The input may be accepted only when the output register is empty or is being drained in the same cycle. An output held with `out_valid` high and `out_ready` low keeps its value until it is taken.

Top module: `colour_matrix`

## Requirements
- R1: Each product of a pixel and a weight is truncated toward minus infinity to 6 fraction bits. The three truncated terms of a row are summed. The sum is then rounded to 3 fraction bits by adding 1 at the 2^-4 weight and truncating toward minus infinity, so exact halves round upward.
- R2: Weight n (n = 1..9, row-major: k(r,c) is weight 3r+c+1) is stored in two locations. Its low 8 bits are at address 2(n-1). Bits [11:8] are written from data bits [3:0] at address 2(n-1)+1. The stored value is signed with 9 fraction bits, so 0x200 means +1.0 and 0x800 means -4.0.
- R3: Data bits [7:4] written to an odd weight address are discarded. Reading any odd weight address returns zero in bits [7:4].
- R4: Writes to addresses 18 to 31 change no stored weight and no output. Reads from those addresses return 0.
- R5: When `wide_mode` was 1 at acceptance, each output is the low 10 integer bits and 3 fraction bits of the rounded sum. Higher bits are dropped, so the value wraps.
- R6: When `wide_mode` was 0 at acceptance, only the low 9 integer bits are kept, and they are sign-extended into the 13-bit output (bit 12 equals bit 11).
- R7: `in_ready` is high exactly when the output register is empty or `out_ready` is high. With `out_ready` held high, a sample accepted at one rising edge is presented with `out_valid` after the second following rising edge, three register stages in all.
- R8: While `out_valid` is high and `out_ready` is low, the outputs and `out_valid` stay unchanged at the next edge.
- R9: After reset, `out_valid` is low and every weight reads back as zero.
- R10: A sample uses the weights held just before its accepting edge. A weight written on that same edge or later does not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Register write strobe, one write per cycle |
| cfg_addr | input | 5 | Register byte address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Read data for `cfg_addr` (combinational) |
| wide_mode | input | 1 | 1: 10 integer bits out, 0: 9 integer bits out; travels with the sample |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Input sample taken on this edge if valid |
| in_a | input | 13 | Channel A, signed 10.3 |
| in_b | input | 13 | Channel B, signed 10.3 |
| in_c | input | 13 | Channel C, signed 10.3 |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Downstream takes the output |
| out_x | output | 13 | Row 1 result, signed 10.3 or sign-extended 9.3 |
| out_y | output | 13 | Row 2 result |
| out_z | output | 13 | Row 3 result |

## Verification
The bench sweeps every 13-bit value of channel A against a fixed matrix that includes the extreme weights -4.0 and just under +4.0. With those weights, a design that kept too few accumulator bits would wrap instead of matching the arithmetic sum. Weights of one least-significant step are placed against pixels that land exactly on rounding halves, positive and negative. A design that rounded toward zero, or truncated before the final rounding in the wrong place, would be off by one at those points. The width select alternates per sample, which exposes a mode that is applied at the wrong pipeline stage or sign-extended from the wrong bit. Random back-pressure, a weight write that lands on the same edge as an accepted sample, and odd-address writes with junk in the upper nibble catch lost or duplicated samples, early weight use and stored sign bits.

// File: rtl/cmx_pkg.sv
package cmx_pkg;
  localparam int CH        = 3;
  localparam int PIX_W     = 13;
  localparam int PIX_FRAC  = 3;
  localparam int COEF_W    = 12;
  localparam int COEF_FRAC = 9;
  localparam int ACC_FRAC  = 6;
  localparam int ADDR_W    = 5;
  localparam int BYTE_W    = 8;
endpackage

// File: rtl/cmx_coef_bank.sv
module cmx_coef_bank #(
  parameter int COEF_W = 12,
  parameter int NCOEF  = 9,
  parameter int ADDR_W = 5,
  parameter int BYTE_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [BYTE_W-1:0]             wdata,
  output logic [BYTE_W-1:0]             rdata,
  output logic [NCOEF-1:0][COEF_W-1:0]  coefs
);
  localparam int HI_W = COEF_W - BYTE_W;

  logic [NCOEF-1:0][BYTE_W-1:0] lo_q;
  logic [NCOEF-1:0][HI_W-1:0]   hi_q;

  for (genvar i = 0; i < NCOEF; i++) begin : g_word
    localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(2 * i);
    localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(2 * i + 1);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q[i] <= '0;
        hi_q[i] <= '0;
      end else if (we) begin
        if (addr == A_LO) lo_q[i] <= wdata;
        if (addr == A_HI) hi_q[i] <= wdata[HI_W-1:0];
      end
    end
    assign coefs[i] = {hi_q[i], lo_q[i]};
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NCOEF; i++) begin
      if (addr == ADDR_W'(2 * i))     rdata = lo_q[i];
      if (addr == ADDR_W'(2 * i + 1)) rdata = {{(BYTE_W-HI_W){1'b0}}, hi_q[i]};
    end
  end
endmodule

// File: rtl/cmx_mul_stage.sv
module cmx_mul_stage #(
  parameter int CH     = 3,
  parameter int PIX_W  = 13,
  parameter int COEF_W = 12,
  parameter int DROP   = 6,
  parameter int TERM_W = PIX_W + COEF_W - DROP
) (
  input  logic                            clk,
  input  logic                            en,
  input  logic [CH-1:0][PIX_W-1:0]        pix,
  input  logic [CH*CH-1:0][COEF_W-1:0]    coefs,
  output logic [CH*CH-1:0][TERM_W-1:0]    terms
);
  localparam int PROD_W = PIX_W + COEF_W;

  for (genvar r = 0; r < CH; r++) begin : g_row
    for (genvar c = 0; c < CH; c++) begin : g_col
      localparam int K = r * CH + c;
      logic signed [PROD_W-1:0] pe, ce, pr;
      assign pe = {{(PROD_W-PIX_W){pix[c][PIX_W-1]}}, pix[c]};
      assign ce = {{(PROD_W-COEF_W){coefs[K][COEF_W-1]}}, coefs[K]};
      assign pr = pe * ce;
      always_ff @(posedge clk) begin
        if (en) terms[K] <= TERM_W'(pr >>> DROP);
      end
    end
  end
endmodule

// File: rtl/cmx_sum_round.sv
module cmx_sum_round #(
  parameter int CH     = 3,
  parameter int TERM_W = 19,
  parameter int ACC_W  = 21,
  parameter int RSH    = 3,
  parameter int PIX_W  = 13
) (
  input  logic                          clk,
  input  logic                          en,
  input  logic [CH*CH-1:0][TERM_W-1:0]  terms,
  input  logic                          wide,
  output logic [CH-1:0][PIX_W-1:0]      res
);
  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) <<< (RSH - 1);

  logic [CH-1:0][ACC_W-1:0] acc_q;

  for (genvar r = 0; r < CH; r++) begin : g_row
    logic signed [ACC_W-1:0] sum_d;
    always_comb begin
      sum_d = '0;
      for (int c = 0; c < CH; c++) begin
        sum_d = sum_d + ACC_W'($signed(terms[r*CH+c]));
      end
    end
    always_ff @(posedge clk) begin
      if (en) acc_q[r] <= sum_d;
    end

    logic signed [ACC_W-1:0] q;
    logic [PIX_W-2:0]        nb;
    assign q  = ($signed(acc_q[r]) + HALF) >>> RSH;
    assign nb = (PIX_W-1)'(q);
    always_ff @(posedge clk) begin
      if (en) res[r] <= wide ? PIX_W'(q) : {nb[PIX_W-2], nb};
    end
  end
endmodule

// File: rtl/colour_matrix.sv
module colour_matrix
  import cmx_pkg::*;
#(
  parameter int P_PIX_W     = PIX_W,
  parameter int P_PIX_FRAC  = PIX_FRAC,
  parameter int P_COEF_W    = COEF_W,
  parameter int P_COEF_FRAC = COEF_FRAC,
  parameter int P_ACC_FRAC  = ACC_FRAC,
  parameter int P_ADDR_W    = ADDR_W,
  parameter int P_BYTE_W    = BYTE_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [P_ADDR_W-1:0]   cfg_addr,
  input  logic [P_BYTE_W-1:0]   cfg_wdata,
  output logic [P_BYTE_W-1:0]   cfg_rdata,
  input  logic                  wide_mode,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [P_PIX_W-1:0]    in_a,
  input  logic [P_PIX_W-1:0]    in_b,
  input  logic [P_PIX_W-1:0]    in_c,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [P_PIX_W-1:0]    out_x,
  output logic [P_PIX_W-1:0]    out_y,
  output logic [P_PIX_W-1:0]    out_z
);
  localparam int NCOEF  = CH * CH;
  localparam int DROP   = P_PIX_FRAC + P_COEF_FRAC - P_ACC_FRAC;
  localparam int TERM_W = P_PIX_W + P_COEF_W - DROP;
  localparam int ACC_W  = TERM_W + $clog2(CH) + 1;
  localparam int RSH    = P_ACC_FRAC - P_PIX_FRAC;

  logic [NCOEF-1:0][P_COEF_W-1:0] coefs;
  logic [NCOEF-1:0][TERM_W-1:0]   terms;
  logic [CH-1:0][P_PIX_W-1:0]     pix, res;
  logic adv;
  logic v1_q, v2_q, v3_q;
  logic m1_q, m2_q, s3_wide;

  cmx_coef_bank #(.COEF_W(P_COEF_W), .NCOEF(NCOEF), .ADDR_W(P_ADDR_W), .BYTE_W(P_BYTE_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .coefs(coefs)
  );

  assign pix = {in_c, in_b, in_a};
  assign adv = !v3_q || out_ready;
  assign in_ready = adv;

  cmx_mul_stage #(.CH(CH), .PIX_W(P_PIX_W), .COEF_W(P_COEF_W), .DROP(DROP), .TERM_W(TERM_W)) u_mul (
    .clk(clk), .en(adv), .pix(pix), .coefs(coefs), .terms(terms)
  );

  cmx_sum_round #(.CH(CH), .TERM_W(TERM_W), .ACC_W(ACC_W), .RSH(RSH), .PIX_W(P_PIX_W)) u_sum (
    .clk(clk), .en(adv), .terms(terms), .wide(m2_q), .res(res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0; v2_q <= 1'b0; v3_q <= 1'b0;
      m1_q <= 1'b0; m2_q <= 1'b0; s3_wide <= 1'b0;
    end else if (adv) begin
      v1_q <= in_valid;  v2_q <= v1_q;  v3_q <= v2_q;
      m1_q <= wide_mode; m2_q <= m1_q;  s3_wide <= m2_q;
    end
  end

  assign out_valid = v3_q;
  assign out_x = res[0];
  assign out_y = res[1];
  assign out_z = res[2];
endmodule

// File: rtl/colour_matrix_checks.sv
module colour_matrix_checks #(
  parameter int PIX_W  = 13,
  parameter int ADDR_W = 5,
  parameter int BYTE_W = 8,
  parameter int NCOEF  = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [BYTE_W-1:0] cfg_rdata,
  input logic              out_valid,
  input logic              out_ready,
  input logic [PIX_W-1:0]  out_x,
  input logic [PIX_W-1:0]  out_y,
  input logic [PIX_W-1:0]  out_z,
  input logic              s3_wide
);
  localparam logic [ADDR_W-1:0] A_END = ADDR_W'(2 * NCOEF);

  a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_x) && $stable(out_y) && $stable(out_z));

  a_r3_hi_nibble_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr[0] && cfg_addr < A_END) |-> cfg_rdata[BYTE_W-1:4] == '0);

  a_r4_unused_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr >= A_END) |-> cfg_rdata == '0);

  a_r6_narrow_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !s3_wide) |->
      (out_x[PIX_W-1] == out_x[PIX_W-2]) && (out_y[PIX_W-1] == out_y[PIX_W-2]) &&
      (out_z[PIX_W-1] == out_z[PIX_W-2]));

  a_r9_empty_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);
endmodule

bind colour_matrix colour_matrix_checks #(
  .PIX_W(P_PIX_W), .ADDR_W(P_ADDR_W), .BYTE_W(P_BYTE_W), .NCOEF(NCOEF)
) u_checks (
  .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata),
  .out_valid(out_valid), .out_ready(out_ready),
  .out_x(out_x), .out_y(out_y), .out_z(out_z), .s3_wide(s3_wide)
);

// File: tb/colour_matrix_test.sv
`timescale 1ns/1ps
module colour_matrix_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [4:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic wide_mode = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [12:0] in_a = '0, in_b = '0, in_c = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [12:0] out_x, out_y, out_z;

  always #2.5 clk = ~clk;

  colour_matrix uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .wide_mode(wide_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_a(in_a), .in_b(in_b), .in_c(in_c),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_x(out_x), .out_y(out_y), .out_z(out_z)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;
  bit stall_mode = 0;
  bit lat_check = 1;
  longint cyc = 0;
  logic [31:0] lf = 32'h1234_5678;
  logic [31:0] sf = 32'h0BAD_F00D;
  logic [11:0] shadow [9];
  logic [38:0] exp_q [$];
  longint      cyc_q [$];

  function automatic logic [31:0] step(logic [31:0] s);
    logic [31:0] x = s;
    x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
    return x;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // R1, R5, R6 arithmetic model
  function automatic logic [12:0] row(logic [11:0] k0, logic [11:0] k1, logic [11:0] k2,
                                      logic [12:0] a, logic [12:0] b, logic [12:0] c, bit wide);
    longint s, r;
    logic [63:0] rv;
    s = ((longint'($signed(k0)) * longint'($signed(a))) >>> 6)
      + ((longint'($signed(k1)) * longint'($signed(b))) >>> 6)
      + ((longint'($signed(k2)) * longint'($signed(c))) >>> 6);
    r = (s + 4) >>> 3;
    rv = r;
    return wide ? rv[12:0] : {rv[11], rv[11:0]};
  endfunction

  function automatic logic [38:0] model(logic [12:0] a, logic [12:0] b, logic [12:0] c, bit wide);
    return {row(shadow[6], shadow[7], shadow[8], a, b, c, wide),
            row(shadow[3], shadow[4], shadow[5], a, b, c, wide),
            row(shadow[0], shadow[1], shadow[2], a, b, c, wide)};
  endfunction

  // monitor: checks R1, R5, R6, R7, R8, R10 through the scoreboard
  always @(negedge clk) begin
    cyc++;
    if (rst_n && !finished) begin
      if (in_valid && in_ready) begin
        exp_q.push_back(model(in_a, in_b, in_c, wide_mode));
        cyc_q.push_back(cyc);
      end
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(0, "R7 unexpected output", {out_z, out_y, out_x}, 0);
        end else begin
          logic [38:0] e;
          longint pc;
          e = exp_q.pop_front();
          pc = cyc_q.pop_front();
          chk({out_z, out_y, out_x} == e, "R1/R5/R6/R8/R10 result", {out_z, out_y, out_x}, e);
          if (lat_check) chk(cyc - pc == 3, "R7 latency", cyc - pc, 3);
        end
      end
    end
  end

  // R8 downstream back-pressure
  always @(posedge clk) begin
    #1;
    sf = step(sf);
    out_ready = stall_mode ? (sf[3:0] > 4'd5) : 1'b1;
  end

  task automatic wr(logic [4:0] a, logic [7:0] d);
    @(posedge clk); #1;
    cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    if (a < 5'd18) begin
      if (a[0]) shadow[a >> 1][11:8] = d[3:0];
      else      shadow[a >> 1][7:0]  = d;
    end
  endtask

  task automatic set_coef(int n, logic [11:0] v);
    wr(5'(2 * n), v[7:0]);
    wr(5'(2 * n + 1), {4'hC, v[11:8]});
  endtask

  task automatic rd_chk(logic [4:0] a, logic [7:0] e, string req);
    cfg_addr = a;
    #1;
    chk(cfg_rdata == e, req, cfg_rdata, e);
  endtask

  task automatic send(logic [12:0] a, logic [12:0] b, logic [12:0] c, bit wide);
    @(posedge clk); #1;
    in_a = a; in_b = b; in_c = c; wide_mode = wide; in_valid = 1'b1;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    stall_mode = 0;
    repeat (12) @(posedge clk);
    #1;
    chk(exp_q.size() == 0, "R7 all samples delivered", exp_q.size(), 0);
  endtask

  initial begin
    for (int i = 0; i < 9; i++) shadow[i] = '0;
    repeat (4) @(posedge clk);
    #1;
    // R9 reset state
    chk(out_valid == 1'b0, "R9 out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(out_valid == 1'b0, "R9 out_valid after reset", out_valid, 0);
    for (int a = 0; a < 18; a++) rd_chk(5'(a), 8'h00, "R9 weight zero after reset");

    // R2, R3 byte map and upper nibble
    for (int n = 0; n < 9; n++) begin
      wr(5'(2 * n), 8'(8'h11 * (n + 1)));
      wr(5'(2 * n + 1), 8'(8'hA0 | n));
    end
    for (int n = 0; n < 9; n++) begin
      rd_chk(5'(2 * n), 8'(8'h11 * (n + 1)), "R2 low byte readback");
      rd_chk(5'(2 * n + 1), 8'(n), "R3 high nibble readback");
    end

    // R4 unused addresses
    for (int a = 18; a < 32; a++) wr(5'(a), 8'hFF);
    for (int a = 18; a < 32; a++) rd_chk(5'(a), 8'h00, "R4 unused address reads zero");
    for (int n = 0; n < 9; n++) rd_chk(5'(2 * n), 8'(8'h11 * (n + 1)), "R4 weights unchanged");
    send(13'h0123, 13'h1F00, 13'h0AAA, 1'b1);   // R4 output uses unchanged weights
    drain();

    // R1 rounding halves: one-step weight
    set_coef(0, 12'h001); set_coef(1, 12'h000); set_coef(2, 12'h000);
    set_coef(3, 12'h000); set_coef(4, 12'h800); set_coef(5, 12'h000);
    set_coef(6, 12'h200); set_coef(7, 12'h000); set_coef(8, 12'hE92);
    foreach (shadow[i]) rd_chk(5'(2 * i), shadow[i][7:0], "R2 weight low byte");
    for (int p = -1024; p <= 1024; p += 64) begin
      send(13'(p), 13'(p), 13'(p), p[6]);
    end
    drain();

    // R5, R6, R1 full sweep of channel A with extreme weights
    set_coef(0, 12'h200); set_coef(1, 12'h7FF); set_coef(2, 12'h800);
    set_coef(3, 12'hE92); set_coef(4, 12'h001); set_coef(5, 12'h800);
    set_coef(6, 12'h800); set_coef(7, 12'h800); set_coef(8, 12'h7FF);
    for (int p = 0; p < 8192; p++) begin
      logic [12:0] a;
      a = 13'(p);
      send(a, a ^ 13'h1555, ~a, a[0]);
    end
    drain();

    // R8 random data under back-pressure
    lat_check = 0;
    stall_mode = 1;
    for (int k = 0; k < 1500; k++) begin
      if (k % 100 == 0) begin
        stall_mode = 0;
        repeat (8) @(posedge clk);
        for (int n = 0; n < 9; n++) begin
          lf = step(lf);
          set_coef(n, lf[11:0]);
        end
        stall_mode = 1;
      end
      lf = step(lf);
      send(lf[12:0], lf[25:13], {lf[31:26], lf[6:0]}, lf[3]);
    end
    drain();
    lat_check = 1;

    // R10 write on the accepting edge
    set_coef(0, 12'h200);
    fork
      send(13'h0100, 13'h0000, 13'h0000, 1'b1);
      wr(5'd0, 8'h55);
    join
    send(13'h0100, 13'h0000, 13'h0000, 1'b1);
    drain();

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog timeout actual=%0d expected=0", exp_q.size());
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule